// File: doc/BRIEF.md
# Board Interrupt Level Aggregator

This block collects thirteen level-sensitive interrupt lines from onboard peripherals and turns them into one 4-bit prioritized level code for a processor. Each line has a fixed bit in a 16-bit monitor vector and a fixed priority. A line takes part only while it is high and its bit is set in a mask register that software can write. Among the lines that take part, the most urgent one sets the output code. That code is the selected level inverted in four bits, so an idle board drives 0.

The block sits on a small synchronous register bus. The bus has a 6-bit byte address, a 16-bit data path, and separate write and read strobes. Behind the bus are four registers: the interrupt mask, a constant version word, a general-purpose output word that drives a 16-bit output bus, and a power-off command. A write to the power-off command with bit 0 set raises a one-cycle shutdown request. All other addresses in the 64-byte window read as zero and ignore writes.

Top module: `brd_irl_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the mask and the output word to 0. After reset, `lvl_code`, `shutdown_req` and `rd_data` are all 0.
- R2: Input `irq_in[k]` has priority level k, where level 0 is the most urgent. It maps to mask bit 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15 for k = 0 to 12, in that order.
- R3: A line counts as active only when it is high and its mapped mask bit is 1. The smallest level among the active lines is selected.
- R4: `lvl_code` equals 15 minus the selected level, which is the level XOR 15. With no line active, the code is 0.
- R5: `lvl_code` is registered. It follows an input change on the next clock edge. It follows a mask write one edge after the edge that stores the mask.
- R6: The mask register is at byte address 0x00. All 16 of its bits can be written and read back.
- R7: The power-off register is at 0x30 and always reads 0. A write with data bit 0 set makes `shutdown_req` high for exactly the one cycle after the write edge. A write with bit 0 clear makes no pulse.
- R8: The version register is at 0x32. It always reads 0x0010, and writes to it change nothing.
- R9: The output-word register is at 0x36. It can be read and written, and `gpo` always shows its value.
- R10: Any other address from 0x00 to 0x3F, including odd ones, reads 0. A write to such an address leaves the mask, the output word, `lvl_code` and `shutdown_req` unchanged.
- R11: `rd_data` is registered. It carries the addressed value in the cycle after a cycle with `rd_en` high, and 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 13 | Level interrupt lines, index = priority level |
| addr | input | 6 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| lvl_code | output | 4 | Encoded interrupt level (selected level XOR 15) |
| gpo | output | 16 | General-purpose output word |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
The hardest case to reach from the ports is an input pattern where a more urgent line is high but masked off, while a less urgent line is high and unmasked. The output must then skip the blocked line. That only happens with mask and input patterns chosen together. The stimulus first sweeps every single line and every pair of lines under a full mask. It then runs a long pseudo-random walk that changes the mask through the bus and the input lines together. Each step is checked against a priority scan computed in the bench. A separate sweep writes to every address in the window and checks that the unimplemented ones move no state.

// File: rtl/brd_irl_pkg.sv
package brd_irl_pkg;

    localparam int NUM_SRC = 13;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 6;
    localparam int LVL_W   = 4;

    localparam logic [LVL_W-1:0]  LVL_IDLE   = '1;
    localparam logic [DATA_W-1:0] VERSION_ID = 16'h0010;

    localparam logic [ADDR_W-1:0] OFS_MASK = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_PWR  = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_VER  = 6'h32;
    localparam logic [ADDR_W-1:0] OFS_GPO  = 6'h36;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_PWR,
        SEL_VER,
        SEL_GPO
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    // Mask/monitor bit position for the line of a given priority level.
    function automatic logic [3:0] src_bit(input int lvl);
        case (lvl)
            0:       return 4'd11;
            1:       return 4'd9;
            2:       return 4'd8;
            3:       return 4'd12;
            4:       return 4'd10;
            5:       return 4'd6;
            6:       return 4'd5;
            7:       return 4'd4;
            8:       return 4'd7;
            9:       return 4'd14;
            10:      return 4'd13;
            11:      return 4'd0;
            default: return 4'd15;
        endcase
    endfunction

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_MASK: return SEL_MASK;
            OFS_PWR:  return SEL_PWR;
            OFS_VER:  return SEL_VER;
            OFS_GPO:  return SEL_GPO;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/brd_irl_encoder.sv
module brd_irl_encoder
    import brd_irl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   irq_in,
    input  logic [DATA_W-1:0]    mask,
    output logic [LVL_W-1:0]     lvl_code
);

    logic [NUM_SRC-1:0] hit;
    pick_t              pick;
    logic [LVL_W-1:0]   code_d;

    // One gating term per source, each tied to its own mask bit.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        localparam logic [3:0] MB = src_bit(g);
        assign hit[g] = irq_in[g] & mask[MB];
    end

    // Scan from least to most urgent so the lowest level is kept last.
    always_comb begin
        pick = '{hit: 1'b0, lvl: LVL_IDLE};
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (hit[i]) begin
                pick.hit = 1'b1;
                pick.lvl = LVL_W'(i);
            end
        end
        code_d = pick.lvl ^ LVL_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_code <= '0;
        else     lvl_code <= code_d;
    end

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hit) == '0) |-> (lvl_code == '0));

    // R3
    top_level_chk: assert property (@(posedge clk) disable iff (rst)
        $past(irq_in[0] & mask[src_bit(0)]) |-> (lvl_code == LVL_IDLE));

    // R5
    code_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_code != '0) |-> ($past(hit) != '0));

endmodule

// File: rtl/brd_irl_regs.sv
module brd_irl_regs
    import brd_irl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] gpo_q,
    output logic              shutdown_req
);

    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_mux;

    assign sel = decode(req.addr);

    always_comb begin
        case (sel)
            SEL_MASK: rd_mux = mask_q;
            SEL_VER:  rd_mux = VERSION_ID;
            SEL_GPO:  rd_mux = gpo_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q       <= '0;
            gpo_q        <= '0;
            shutdown_req <= 1'b0;
            rd_data      <= '0;
        end else begin
            shutdown_req <= req.wr && (sel == SEL_PWR) && req.wdata[0];
            rd_data      <= req.rd ? rd_mux : '0;
            if (req.wr && sel == SEL_MASK) mask_q <= req.wdata;
            if (req.wr && sel == SEL_GPO)  gpo_q  <= req.wdata;
        end
    end

    // R7
    shutdown_cause_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(req.wr && req.addr == OFS_PWR && req.wdata[0]));

    // R8
    version_read_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req.rd && req.addr == OFS_VER) |-> (rd_data == VERSION_ID));

    // R9
    gpo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(req.wr && req.addr == OFS_GPO) |-> $stable(gpo_q));

    // R11
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(req.rd) |-> (rd_data == '0));

endmodule

// File: rtl/brd_irl_ctrl.sv
module brd_irl_ctrl
    import brd_irl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [12:0]         irq_in,
    input  logic [5:0]          addr,
    input  logic                wr_en,
    input  logic [15:0]         wr_data,
    input  logic                rd_en,
    output logic [15:0]         rd_data,
    output logic [3:0]          lvl_code,
    output logic [15:0]         gpo,
    output logic                shutdown_req
);

    bus_req_t          req;
    logic [DATA_W-1:0] mask_q;

    assign req = '{wr: wr_en, rd: rd_en, addr: addr, wdata: wr_data};

    brd_irl_regs i_regs (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .rd_data      (rd_data),
        .mask_q       (mask_q),
        .gpo_q        (gpo),
        .shutdown_req (shutdown_req)
    );

    brd_irl_encoder i_enc (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .mask     (mask_q),
        .lvl_code (lvl_code)
    );

endmodule

// File: tb/test_brd_irl_ctrl.sv
module test_brd_irl_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] irq_in = '0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [3:0]  lvl_code;
    logic [15:0] gpo;
    logic        shutdown_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic sd_first, sd_second;
    logic [15:0] rval;
    logic [15:0] cur_mask;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2 clk = ~clk;

    brd_irl_ctrl i_brd_irl_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .lvl_code(lvl_code), .gpo(gpo), .shutdown_req(shutdown_req)
    );

    function automatic int bit_of(int k);
        int tbl[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
        return tbl[k];
    endfunction

    function automatic logic [3:0] exp_code(logic [12:0] inp, logic [15:0] m);
        int best = 15;
        for (int k = 12; k >= 0; k--)
            if (inp[k] && m[bit_of(k)]) best = k;
        return 4'(15 - best);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        sd_first = shutdown_req;
        @(negedge clk);
        sd_second = shutdown_req;
    endtask

    task automatic bus_rd(logic [5:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        rval = rd_data;
    endtask

    task automatic set_inputs(logic [12:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 lvl", lvl_code, 0);
        chk("R1 gpo", gpo, 0);
        chk("R1 shutdown", shutdown_req, 0);
        chk("R1 rd_data", rd_data, 0);
        bus_rd(6'h00);
        chk("R1 mask", rval, 0);

        // R4 all lines high, mask clear -> idle
        set_inputs('1);
        chk("R4 masked idle", lvl_code, 0);
        set_inputs('0);

        // R6 mask readback
        bus_wr(6'h00, 16'hFFFF);
        bus_rd(6'h00);
        chk("R6 mask ones", rval, 16'hFFFF);
        @(negedge clk);
        // R11 no read -> 0
        chk("R11 idle rd", rd_data, 0);

        // R2/R3/R4 single-line sweep under full mask
        for (int k = 0; k < 13; k++) begin
            set_inputs(13'(1 << k));
            chk("R2 single", lvl_code, 15 - k);
        end
        // R3 pair sweep
        for (int a = 0; a < 13; a++)
            for (int b = a + 1; b < 13; b++) begin
                set_inputs(13'((1 << a) | (1 << b)));
                chk("R3 pair", lvl_code, 15 - a);
            end
        // R2 mask bit per line: only that bit enabled
        for (int k = 0; k < 13; k++) begin
            bus_wr(6'h00, 16'(1 << bit_of(k)));
            set_inputs('1);
            chk("R2 mask bit", lvl_code, 15 - k);
        end

        // R5 timing: input change seen after one edge only
        bus_wr(6'h00, 16'hFFFF);
        set_inputs('0);
        @(negedge clk);
        irq_in = 13'h0010;
        chk("R5 before edge", lvl_code, 0);
        @(negedge clk);
        chk("R5 after edge", lvl_code, 11);
        // R5 mask write: one extra edge after the mask is stored
        @(negedge clk);
        addr = 6'h00; wr_data = 16'h0000; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 mask stored, code old", lvl_code, 11);
        @(negedge clk);
        chk("R5 mask code new", lvl_code, 0);

        // R3 random walk of mask and inputs
        cur_mask = 16'h0;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (n % 3 == 0) begin
                cur_mask = lfsr[15:0];
                bus_wr(6'h00, cur_mask);
            end
            set_inputs(lfsr[28:16]);
            chk("R3 random", lvl_code, exp_code(lfsr[28:16], cur_mask));
        end

        // R7 power-off
        bus_rd(6'h30);
        chk("R7 read zero", rval, 0);
        bus_wr(6'h30, 16'h0001);
        chk("R7 pulse", sd_first, 1);
        chk("R7 pulse width", sd_second, 0);
        bus_wr(6'h30, 16'hFFFE);
        chk("R7 no pulse", sd_first, 0);

        // R9 output word
        bus_wr(6'h36, 16'hBEEF);
        chk("R9 gpo", gpo, 16'hBEEF);
        bus_rd(6'h36);
        chk("R9 read", rval, 16'hBEEF);

        // R8 version
        bus_wr(6'h32, 16'hFFFF);
        bus_rd(6'h32);
        chk("R8 version", rval, 16'h0010);
        chk("R8 gpo untouched", gpo, 16'hBEEF);

        // R10 address sweep
        bus_wr(6'h00, 16'hA5A5);
        bus_wr(6'h36, 16'h5A5A);
        set_inputs(13'h1FFF);
        for (int a = 0; a < 64; a++) begin
            if (a == 'h00 || a == 'h30 || a == 'h32 || a == 'h36) continue;
            bus_wr(6'(a), 16'hFFFF);
            chk("R10 no pulse", sd_first, 0);
            bus_rd(6'(a));
            chk("R10 read zero", rval, 0);
            chk("R10 gpo", gpo, 16'h5A5A);
            chk("R10 lvl", lvl_code, exp_code(13'h1FFF, 16'hA5A5));
        end
        bus_rd(6'h00);
        chk("R10 mask kept", rval, 16'hA5A5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule